// File: doc/BRIEF.md
# Word-Addressed Bus Address Router

This block connects one bus master to several memory-mapped slaves on a 32-bit bus with word-aligned addresses. The bus has read and write strobes, byte enables, write data, read data and a wait-request handshake. Each slave port has a base address and an address mask that are fixed at elaboration. When the master starts an access, the router takes a registered copy of the request. It decodes that copy and routes the access to the first slave whose masked address equals its base. The slave receives a word index relative to its own window, plus the master's write data and byte enables. The slave's wait-request and read data go back to the master.

The router stays on the chosen slave until that slave releases wait-request. Changes on the master inputs during wait states cannot move the transfer to another target. If an address is misaligned, the router does not forward the access. It does the same for an address that falls in a hole in the map. In both cases it ends the transfer at once with zero read data and sets a sticky error flag. The master therefore never hangs, and software can still find out that a bad access happened.

Top module: `mm_addr_router`

## Requirements
- R1: A slave matches when (address AND its mask) equals its base. When several slaves match, the one with the lowest index is chosen.
- R2: The selected slave, and no other, gets a read or write strobe. `s_offset` carries (address AND NOT mask) shifted right by two, for the mask of the selected slave.
- R3: Write data and byte enables reach the slaves unchanged.
- R4: `m_readdata` returns the read data of the selected slave in the cycle in which that slave's wait-request is low.
- R5: In the cycle in which a request is first seen, `m_waitrequest` is high. The cycle after that is the first routed cycle. From then on, `m_waitrequest` follows the selected slave, so a slave that waits W cycles completes in the (W+1)-th routed cycle.
- R6: The request is captured when it is first seen. Changing `m_address` during wait states does not change the target, the offset or the data returned.
- R7: An access with address bits [1:0] not equal to 00 strobes no slave. It completes in the first routed cycle with `m_readdata` = 0 and sets `err_unaligned`. This check takes precedence over the hole check, so a misaligned access to a hole sets no hole flag.
- R8: An aligned access that matches no slave strobes no slave. It completes in the first routed cycle with `m_readdata` = 0. It sets `err_hole_rd` for a read or `err_hole_wr` for a write.
- R9: The error flags stay set through later good transfers. Only reset clears them. During reset all flags and all slave strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_address | input | AW | Master byte address |
| m_read | input | 1 | Master read strobe |
| m_write | input | 1 | Master write strobe |
| m_writedata | input | DW | Master write data |
| m_byteenable | input | DW/8 | Master byte enables |
| m_readdata | output | DW | Read data returned to the master |
| m_waitrequest | output | 1 | Stall to the master |
| s_read | output | NSLV | Read strobe, one bit per slave |
| s_write | output | NSLV | Write strobe, one bit per slave |
| s_offset | output | AW-2 | Word index relative to the slave's base |
| s_writedata | output | DW | Write data to the slaves |
| s_byteenable | output | DW/8 | Byte enables to the slaves |
| s_readdata | input | NSLV*DW | Read data from the slaves, slave i in bits [i*DW +: DW] |
| s_waitrequest | input | NSLV | Wait-request from each slave |
| err_unaligned | output | 1 | Sticky flag: misaligned access seen |
| err_hole_rd | output | 1 | Sticky flag: read of an unmapped address |
| err_hole_wr | output | 1 | Sticky flag: write of an unmapped address |

## Verification
The address map used in the tests has two slaves that overlap. Addresses inside the overlap show whether priority picks the lower index. Addresses that only the wider window covers show that the lower slave's mask does not leak into the offset. The three slaves have different wait counts of zero, one and two cycles, so the measured completion latency shows which slave answered and that the stall follows that slave.

Error behaviour is tested in four ways:
- A hole read and a hole write, to separate the two direction flags.
- A misaligned address inside a hole, to show that the misalignment check wins.
- An address changed in the middle of a wait, to show that the captured request keeps its target.
- A good access after an error, then a reset, to show that the flags stay set until reset and that reset clears them.

// File: rtl/mm_router_pkg.sv
`timescale 1ns/1ps
package mm_router_pkg;

  typedef enum logic {
    RT_IDLE = 1'b0,
    RT_BUSY = 1'b1
  } rt_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mm_req_capture.sv
`timescale 1ns/1ps
module mm_req_capture #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  in_addr,
  input  logic           in_rd,
  input  logic           in_wr,
  input  logic [DW-1:0]  in_wdata,
  input  logic [BEW-1:0] in_be,
  output logic [AW-1:0]  q_addr,
  output logic           q_rd,
  output logic           q_wr,
  output logic [DW-1:0]  q_wdata,
  output logic [BEW-1:0] q_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      q_wdata <= '0;
      q_be    <= '0;
    end else if (load) begin
      q_addr  <= in_addr;
      q_rd    <= in_rd;
      q_wr    <= in_wr;
      q_wdata <= in_wdata;
      q_be    <= in_be;
    end
  end

endmodule

// File: rtl/mm_slave_match.sv
`timescale 1ns/1ps
module mm_slave_match #(
  parameter int NSLV = 3,
  parameter int AW   = 32,
  parameter logic [NSLV-1:0][AW-1:0] BASE = '0,
  parameter logic [NSLV-1:0][AW-1:0] MASK = '0,
  localparam int IW = mm_router_pkg::idx_width(NSLV)
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IW-1:0]   sel_idx,
  output logic [NSLV-1:0] sel_onehot,
  output logic [AW-3:0]   offset
);

  logic [NSLV-1:0] hit_vec;
  logic [AW-1:0]   rel_addr;

  for (genvar g = 0; g < NSLV; g++) begin : g_win
    if ((BASE[g] & MASK[g]) != BASE[g]) begin : g_bad_cfg
      $error("slave window %0d: base has bits outside its mask", g);
    end
    assign hit_vec[g] = ((addr & MASK[g]) == BASE[g]);
  end

  // Scanning from the top down lets the lowest matching index win.
  always_comb begin
    sel_idx = '0;
    for (int i = NSLV - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = IW'(i);
    end
  end

  assign hit        = |hit_vec;
  assign sel_onehot = hit ? (NSLV'(1) << sel_idx) : '0;
  assign rel_addr   = addr & ~MASK[sel_idx];
  assign offset     = hit ? rel_addr[AW-1:2] : '0;

endmodule

// File: rtl/mm_resp_mux.sv
`timescale 1ns/1ps
module mm_resp_mux #(
  parameter int NSLV = 3,
  parameter int DW   = 32,
  localparam int IW  = mm_router_pkg::idx_width(NSLV)
) (
  input  logic [IW-1:0]      sel_idx,
  input  logic [NSLV*DW-1:0] s_readdata,
  input  logic [NSLV-1:0]    s_waitrequest,
  output logic [DW-1:0]      rdata,
  output logic               wait_sel
);

  logic [DW-1:0] rd_arr [NSLV];

  for (genvar g = 0; g < NSLV; g++) begin : g_unpack
    assign rd_arr[g] = s_readdata[g*DW +: DW];
  end

  assign rdata    = rd_arr[sel_idx];
  assign wait_sel = s_waitrequest[sel_idx];

endmodule

// File: rtl/mm_addr_router.sv
`timescale 1ns/1ps
module mm_addr_router #(
  parameter int NSLV = 3,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter logic [NSLV-1:0][AW-1:0] SLV_BASE = {32'h1000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NSLV-1:0][AW-1:0] SLV_MASK = {32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000},
  localparam int BEW = DW / 8,
  localparam int IW  = mm_router_pkg::idx_width(NSLV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      m_address,
  input  logic               m_read,
  input  logic               m_write,
  input  logic [DW-1:0]      m_writedata,
  input  logic [BEW-1:0]     m_byteenable,
  output logic [DW-1:0]      m_readdata,
  output logic               m_waitrequest,
  output logic [NSLV-1:0]    s_read,
  output logic [NSLV-1:0]    s_write,
  output logic [AW-3:0]      s_offset,
  output logic [DW-1:0]      s_writedata,
  output logic [BEW-1:0]     s_byteenable,
  input  logic [NSLV*DW-1:0] s_readdata,
  input  logic [NSLV-1:0]    s_waitrequest,
  output logic               err_unaligned,
  output logic               err_hole_rd,
  output logic               err_hole_wr
);

  import mm_router_pkg::*;

  rt_state_e state_q, state_d;

  logic [AW-1:0]   q_addr;
  logic            q_rd, q_wr;
  logic [DW-1:0]   q_wdata;
  logic [BEW-1:0]  q_be;
  logic            load, busy, aligned, hit, route_ok, done;
  logic [IW-1:0]   sel_idx;
  logic [NSLV-1:0] sel_onehot;
  logic [DW-1:0]   mux_rdata;
  logic            mux_wait;
  logic            unal_d, hrd_d, hwr_d;

  assign load = (state_q == RT_IDLE) && (m_read || m_write);
  assign busy = (state_q == RT_BUSY);

  mm_req_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .in_addr  (m_address),
    .in_rd    (m_read),
    .in_wr    (m_write),
    .in_wdata (m_writedata),
    .in_be    (m_byteenable),
    .q_addr   (q_addr),
    .q_rd     (q_rd),
    .q_wr     (q_wr),
    .q_wdata  (q_wdata),
    .q_be     (q_be)
  );

  mm_slave_match #(.NSLV(NSLV), .AW(AW), .BASE(SLV_BASE), .MASK(SLV_MASK)) u_match (
    .addr       (q_addr),
    .hit        (hit),
    .sel_idx    (sel_idx),
    .sel_onehot (sel_onehot),
    .offset     (s_offset)
  );

  mm_resp_mux #(.NSLV(NSLV), .DW(DW)) u_mux (
    .sel_idx       (sel_idx),
    .s_readdata    (s_readdata),
    .s_waitrequest (s_waitrequest),
    .rdata         (mux_rdata),
    .wait_sel      (mux_wait)
  );

  assign aligned  = (q_addr[1:0] == 2'b00);
  assign route_ok = aligned && hit;

  assign s_read       = (busy && route_ok && q_rd) ? sel_onehot : '0;
  assign s_write      = (busy && route_ok && q_wr) ? sel_onehot : '0;
  assign s_writedata  = q_wdata;
  assign s_byteenable = q_be;

  assign m_waitrequest = busy ? (route_ok ? mux_wait : 1'b0) : 1'b1;
  assign m_readdata    = (busy && route_ok) ? mux_rdata : '0;
  assign done          = busy && !m_waitrequest;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RT_IDLE: if (load) state_d = RT_BUSY;
      RT_BUSY: if (done) state_d = RT_IDLE;
      default: state_d = RT_IDLE;
    endcase
  end

  always_comb begin
    unal_d = err_unaligned;
    hrd_d  = err_hole_rd;
    hwr_d  = err_hole_wr;
    if (busy && !aligned) begin
      unal_d = 1'b1;
    end else if (busy && !hit) begin
      if (q_rd) hrd_d = 1'b1;
      if (q_wr) hwr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= RT_IDLE;
      err_unaligned <= 1'b0;
      err_hole_rd   <= 1'b0;
      err_hole_wr   <= 1'b0;
    end else begin
      state_q       <= state_d;
      err_unaligned <= unal_d;
      err_hole_rd   <= hrd_d;
      err_hole_wr   <= hwr_d;
    end
  end

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_read && m_write));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_read | s_write));

  // R5
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> m_waitrequest);

  // R6
  hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && m_waitrequest) |=> ($stable(s_offset) && $stable(s_read) && $stable(s_write)));

  // R7
  unal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !aligned) |-> (m_readdata == '0 && s_read == '0 && s_write == '0));

  // R8
  hole_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_hole_rd) |-> $past(!m_waitrequest && m_readdata == '0));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unaligned || err_hole_rd || err_hole_wr) |=>
      ((err_unaligned >= $past(err_unaligned)) && (err_hole_rd >= $past(err_hole_rd)) &&
       (err_hole_wr >= $past(err_hole_wr))));

endmodule

// File: tb/mm_addr_router_test.sv
`timescale 1ns/1ps
module mm_addr_router_test;

  localparam int NSLV = 3;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int BEW  = DW / 8;
  localparam logic [NSLV-1:0][AW-1:0] BASES = {32'h1000_0000, 32'h1000_0000, 32'h0000_0000};
  localparam logic [NSLV-1:0][AW-1:0] MASKS = {32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000};
  localparam int WAITS [NSLV] = '{0, 2, 1};

  logic               clk, rst_n;
  logic [AW-1:0]      m_address;
  logic               m_read, m_write;
  logic [DW-1:0]      m_writedata;
  logic [BEW-1:0]     m_byteenable;
  logic [DW-1:0]      m_readdata;
  logic               m_waitrequest;
  logic [NSLV-1:0]    s_read, s_write;
  logic [AW-3:0]      s_offset;
  logic [DW-1:0]      s_writedata;
  logic [BEW-1:0]     s_byteenable;
  logic [NSLV*DW-1:0] s_readdata;
  logic [NSLV-1:0]    s_waitrequest;
  logic               err_unaligned, err_hole_rd, err_hole_wr;

  int checks = 0;
  int failures = 0;

  mm_addr_router #(.NSLV(NSLV), .AW(AW), .DW(DW), .SLV_BASE(BASES), .SLV_MASK(MASKS)) uut (
    .clk(clk), .rst_n(rst_n),
    .m_address(m_address), .m_read(m_read), .m_write(m_write),
    .m_writedata(m_writedata), .m_byteenable(m_byteenable),
    .m_readdata(m_readdata), .m_waitrequest(m_waitrequest),
    .s_read(s_read), .s_write(s_write), .s_offset(s_offset),
    .s_writedata(s_writedata), .s_byteenable(s_byteenable),
    .s_readdata(s_readdata), .s_waitrequest(s_waitrequest),
    .err_unaligned(err_unaligned), .err_hole_rd(err_hole_rd), .err_hole_wr(err_hole_wr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural slaves: slave i stalls WAITS[i] cycles, then answers {A0+i, offset[23:0]}.
  int            cnt      [NSLV];
  int            wr_cnt   [NSLV];
  logic [AW-3:0] wr_off   [NSLV];
  logic [DW-1:0] wr_data  [NSLV];
  logic [BEW-1:0] wr_be   [NSLV];
  int            strobe_cycles;

  always_comb begin
    for (int i = 0; i < NSLV; i++) begin
      s_waitrequest[i] = !((s_read[i] || s_write[i]) && cnt[i] == WAITS[i]);
      s_readdata[i*DW +: DW] = {8'(8'hA0 + i), s_offset[23:0]};
    end
  end

  always @(posedge clk) begin
    if (|(s_read | s_write)) strobe_cycles <= strobe_cycles + 1;
    for (int i = 0; i < NSLV; i++) begin
      if (s_read[i] || s_write[i]) begin
        if (cnt[i] == WAITS[i]) begin
          cnt[i] <= 0;
          if (s_write[i]) begin
            wr_cnt[i]  <= wr_cnt[i] + 1;
            wr_off[i]  <= s_offset;
            wr_data[i] <= s_writedata;
            wr_be[i]   <= s_byteenable;
          end
        end else begin
          cnt[i] <= cnt[i] + 1;
        end
      end else begin
        cnt[i] <= 0;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-3:0] exp_off(input logic [AW-1:0] a, input int s);
    logic [AW-1:0] r;
    r = a & ~MASKS[s];
    return r[AW-1:2];
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a, input int s);
    logic [AW-3:0] o;
    o = exp_off(a, s);
    return {8'(8'hA0 + s), o[23:0]};
  endfunction

  // Runs one transfer; returns read data and number of routed cycles until completion.
  task automatic xfer(input logic [AW-1:0] addr, input bit wr, input logic [DW-1:0] wdata,
                      input logic [BEW-1:0] be, input bit retarget, input logic [AW-1:0] alt,
                      output logic [DW-1:0] rdata, output int lat);
    @(negedge clk);
    m_address = addr; m_read = !wr; m_write = wr; m_writedata = wdata; m_byteenable = be;
    #0.5;
    check("R5", "stall while capturing", 64'(m_waitrequest), 64'(1));
    lat = 0;
    rdata = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      lat++;
      if (!m_waitrequest) begin
        rdata = m_readdata;
        break;
      end
      if (retarget) m_address = alt;
    end
    @(posedge clk);
    @(negedge clk);
    m_read = 1'b0; m_write = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_read = 1'b0; m_write = 1'b0; m_address = '0; m_writedata = '0; m_byteenable = '0;
    repeat (2) @(negedge clk);
    check("R9", "unaligned flag in reset", 64'(err_unaligned), 64'(0));
    check("R9", "hole flags in reset", 64'({err_hole_rd, err_hole_wr}), 64'(0));
    check("R9", "strobes in reset", 64'({s_read, s_write}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reads();
    logic [DW-1:0] rd; int lat;
    xfer(32'h0000_0100, 0, '0, '1, 0, '0, rd, lat);
    check("R4", "slave0 read data", 64'(rd), 64'(exp_rd(32'h0000_0100, 0)));
    check("R5", "slave0 latency", 64'(lat), 64'(WAITS[0] + 1));
    xfer(32'h1000_0040, 0, '0, '1, 0, '0, rd, lat);
    check("R1", "overlap picks slave1", 64'(rd), 64'(exp_rd(32'h1000_0040, 1)));
    check("R5", "slave1 latency", 64'(lat), 64'(WAITS[1] + 1));
    xfer(32'h1234_5678 & ~32'h3, 0, '0, '1, 0, '0, rd, lat);
    check("R2", "slave2 offset via data", 64'(rd), 64'(exp_rd(32'h1234_5678, 2)));
    check("R5", "slave2 latency", 64'(lat), 64'(WAITS[2] + 1));
  endtask

  task automatic t_writes();
    logic [DW-1:0] rd; int lat; int w0, w2;
    w0 = wr_cnt[0]; w2 = wr_cnt[2];
    xfer(32'h0000_0010, 1, 32'hDEAD_BEEF, 4'b0101, 0, '0, rd, lat);
    check("R2", "slave0 write count", 64'(wr_cnt[0]), 64'(w0 + 1));
    check("R2", "slave0 write offset", 64'(wr_off[0]), 64'(exp_off(32'h0000_0010, 0)));
    check("R3", "slave0 write data", 64'(wr_data[0]), 64'(32'hDEAD_BEEF));
    check("R3", "slave0 byte enables", 64'(wr_be[0]), 64'(4'b0101));
    xfer(32'h1003_0000, 1, 32'h0123_4567, 4'b1000, 0, '0, rd, lat);
    check("R2", "slave2 only written", 64'({wr_cnt[2], wr_cnt[0]}), 64'({w2 + 1, w0 + 1}));
    check("R2", "slave2 write offset", 64'(wr_off[2]), 64'(exp_off(32'h1003_0000, 2)));
    check("R3", "slave2 byte enables", 64'(wr_be[2]), 64'(4'b1000));
  endtask

  task automatic t_retarget();
    logic [DW-1:0] rd; int lat;
    xfer(32'h1000_0080, 0, '0, '1, 1, 32'h0000_0000, rd, lat);
    check("R6", "data from captured target", 64'(rd), 64'(exp_rd(32'h1000_0080, 1)));
    check("R6", "latency of captured target", 64'(lat), 64'(WAITS[1] + 1));
  endtask

  task automatic t_unaligned();
    logic [DW-1:0] rd; int lat; int sc;
    sc = strobe_cycles;
    xfer(32'h2000_0001, 0, '0, '1, 0, '0, rd, lat);
    check("R7", "unaligned read data", 64'(rd), 64'(0));
    check("R7", "unaligned latency", 64'(lat), 64'(1));
    check("R7", "no slave strobed", 64'(strobe_cycles), 64'(sc));
    check("R7", "flags after unaligned", 64'({err_unaligned, err_hole_rd, err_hole_wr}), 64'(3'b100));
    xfer(32'h0000_0200, 0, '0, '1, 0, '0, rd, lat);
    check("R9", "flag sticky over good read", 64'(err_unaligned), 64'(1));
    check("R4", "good read after error", 64'(rd), 64'(exp_rd(32'h0000_0200, 0)));
  endtask

  task automatic t_holes();
    logic [DW-1:0] rd; int lat; int sc;
    sc = strobe_cycles;
    xfer(32'h2000_0000, 0, '0, '1, 0, '0, rd, lat);
    check("R8", "hole read data", 64'(rd), 64'(0));
    check("R8", "hole read latency", 64'(lat), 64'(1));
    check("R8", "flags after hole read", 64'({err_unaligned, err_hole_rd, err_hole_wr}), 64'(3'b010));
    xfer(32'h3000_0004, 1, 32'hFFFF_FFFF, '1, 0, '0, rd, lat);
    check("R8", "hole write latency", 64'(lat), 64'(1));
    check("R8", "flags after hole write", 64'({err_unaligned, err_hole_rd, err_hole_wr}), 64'(3'b011));
    check("R8", "no slave strobed on holes", 64'(strobe_cycles), 64'(sc));
  endtask

  initial begin
    strobe_cycles = 0;
    for (int i = 0; i < NSLV; i++) begin
      cnt[i] = 0; wr_cnt[i] = 0; wr_off[i] = '0; wr_data[i] = '0; wr_be[i] = '0;
    end
    do_reset();
    t_reads();
    t_writes();
    t_retarget();
    t_unaligned();
    do_reset();
    t_holes();
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule